// File: doc/BRIEF.md
# Compare-Match Interval Timer with Square-Wave Output

This block is an up-counting interval timer with a compare register. A host programs it through a small write port that has three decoded addresses. One address holds an 8-bit control byte. One holds the compare value. The third is a spare compare slot that this mode never uses. A free-running prescaler produces eight tick rates, and the clock-select field of the control byte picks one of them.

On each selected tick the counter steps up by one. When the counter equals the compare value on a tick, three things happen in that cycle:
- a one-cycle interrupt pulse is raised;
- the counter returns to zero;
- the square-wave output, if enabled, toggles one clock later.

The result is an interrupt every (N+1) ticks and a 50% duty square wave whose period is two intervals.

Clearing the run bit stops the timer. It clears the prescaler and the counter and forces the output to the programmed idle level. The timer is used by writing the compare value, then writing the control byte with the run bit set. The interrupt goes to an external controller, and the output drives a pin.

Top module: `cm_interval_timer`

## Requirements
- R1: During and straight after reset, `tick_irq` is 0 and `wave_out` is 0.
- R2: With compare value N and tick divisor d, the first `tick_irq` pulse is high in the cycle (N+1)*d-1 clocks after the edge that writes the run bit. Further pulses follow every (N+1)*d clocks for as long as the run bit stays 1.
- R3: Clock-select codes 0 to 7 (control bits [6:4]) give tick divisors of 1, 2, 4, 16, 64, 256, 1024 and 4096 system clocks.
- R4: `tick_irq` is exactly one clock wide, except when the divisor is 1 and the compare value is 0. In that case it stays high every cycle.
- R5: With output enable (control bit 0) at 1, `wave_out` inverts in the cycle after every `tick_irq` cycle, starting from the idle level. It holds its level otherwise.
- R6: With output enable at 0, `wave_out` equals the idle-level bit (control bit 1) at all times.
- R7: Writing the run bit (control bit 7) to 0 returns `wave_out` to the idle level in the very next cycle and stops `tick_irq`. A later run restarts from a zero count and a zero prescaler, so the timing of R2 applies again.
- R8: An operating-mode field (control bits [3:2]) other than 00 keeps the counter at zero. No `tick_irq` occurs and `wave_out` stays at the idle level.
- R9: Writes to address 2 (the unused second compare slot) and to address 3 change neither the interrupt timing nor `wave_out`.
- R10: Address 0 writes the control byte with bit 7 run, bits [6:4] clock select, bits [3:2] mode, bit 1 idle level and bit 0 output enable. Address 1 writes the compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address: 0 control, 1 compare, 2 spare compare, 3 unused |
| reg_wdata | input | 8 | Write data |
| tick_irq | output | 1 | Interrupt pulse on compare match |
| wave_out | output | 1 | Square-wave or idle-level output |

## Verification
Two events can fall in the same cycle: a compare-match tick that raises the interrupt and toggles the wave, and a host write. Writes to the spare compare slot and to the unused address are issued on every cycle of a running sweep, so some of them land on match cycles. Each cycle is then judged against the interrupt and wave pattern computed from (N+1)*d alone. A second collision is divisor 1 with compare 0, where every tick matches. Here the interrupt must stay high every cycle and the wave must invert on every edge. Clearing the run bit straight after a toggle is checked for an idle level in the very next cycle.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

   // Control byte layout, MSB first
   typedef struct packed {
      logic       run;
      logic [2:0] csel;
      logic [1:0] opmode;
      logic       idle_lvl;
      logic       wave_en;
   } ctrl_t;

   localparam int unsigned CTRL_W  = $bits(ctrl_t);
   localparam int unsigned NUM_SEL = 8;
   localparam int unsigned SEL_W   = $clog2(NUM_SEL);

   localparam logic [1:0] OPM_INTERVAL = 2'b00;

   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_CMP0 = 2'd1;
   localparam logic [1:0] ADR_CMP1 = 2'd2;

   // Tick divisor exponent for select code k: 0,1,2,4,6,8,10,12
   function automatic int unsigned sel_shift(input int unsigned k);
      return (k < 3) ? k : (2 * k - 2);
   endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
   import cmt_pkg::*;
#(
   parameter int unsigned NSEL = NUM_SEL
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en_i,
   input  logic [$clog2(NSEL)-1:0] sel_i,
   output logic                    tick_o
);
   localparam int unsigned PW = sel_shift(NSEL - 1);

   generate
      if (NSEL < 2) begin : g_bad_nsel
         $error("cmt_prescaler: NSEL must be at least 2");
      end
   endgenerate

   logic [PW-1:0]   pcnt;
   logic [NSEL-1:0] tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pcnt <= '0;
      else if (!en_i) pcnt <= '0;
      else            pcnt <= pcnt + 1'b1;
   end

   generate
      for (genvar k = 0; k < NSEL; k++) begin : g_tap
         localparam int unsigned SH = sel_shift(k);
         if (SH == 0) begin : g_full
            assign tap[k] = 1'b1;
         end else begin : g_div
            assign tap[k] = &pcnt[SH-1:0];
         end
      end
   endgenerate

   assign tick_o = en_i & tap[sel_i];

   // R3: any divided tap never fires two cycles running
   p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && sel_i != '0 && $stable(sel_i) && $past(en_i)) |-> !$past(tick_o));

   // R7: stopped prescaler restarts from zero
   p_pre_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> pcnt == '0);

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] cmp_i,
   output logic             hit_o
);
   logic [CNT_W-1:0] cnt;
   logic             match;

   assign match = (cnt == cmp_i);
   assign hit_o = en_i & tick_i & match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!en_i)  cnt <= '0;
      else if (tick_i) cnt <= match ? '0 : cnt + 1'b1;
   end

   // R2: non-matching tick advances by one
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && tick_i && cnt != cmp_i) |=> cnt == CNT_W'($past(cnt) + 1'b1));

   // R2: match wraps to zero
   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> cnt == '0);

   // R2: no tick, no change
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !tick_i) |=> $stable(cnt));

   // R7 / R8: disabled counter sits at zero
   p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> cnt == '0);

endmodule

// File: rtl/cmt_wave.sv
module cmt_wave (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic wave_en_i,
   input  logic idle_lvl_i,
   input  logic hit_i,
   output logic wave_o
);
   logic tog;
   logic active;

   assign active = run_i & wave_en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tog <= 1'b0;
      else if (!active) tog <= 1'b0;
      else if (hit_i)   tog <= ~tog;
   end

   assign wave_o = idle_lvl_i ^ (tog & active);

   // R5: a match inverts the phase
   p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && hit_i) |=> tog != $past(tog));

   // R5: no match, phase kept
   p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !hit_i) |=> $stable(tog));

   // R6 / R7: inactive output shows the idle level
   p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> tog == 1'b0);

endmodule

// File: rtl/cm_interval_timer.sv
module cm_interval_timer
   import cmt_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_we,
   input  logic [1:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic       tick_irq,
   output logic       wave_out
);
   generate
      if (CNT_W < 2 || CNT_W > CTRL_W) begin : g_bad_width
         $error("cm_interval_timer: CNT_W must be 2..8");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] cmp0_q;
   logic             cnt_en;
   logic             tick;
   logic             hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cmp0_q <= '1;
      end else if (reg_we) begin
         case (reg_addr)
            ADR_CTRL: ctrl_q <= ctrl_t'(reg_wdata);
            ADR_CMP0: cmp0_q <= reg_wdata[CNT_W-1:0];
            default:  ;  // spare compare slot and address 3 ignored
         endcase
      end
   end

   assign cnt_en = ctrl_q.run && (ctrl_q.opmode == OPM_INTERVAL);

   cmt_prescaler #(.NSEL(NUM_SEL)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (cnt_en),
      .sel_i  (ctrl_q.csel),
      .tick_o (tick)
   );

   cmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (cnt_en),
      .tick_i (tick),
      .cmp_i  (cmp0_q),
      .hit_o  (hit)
   );

   cmt_wave u_wave (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (ctrl_q.run),
      .wave_en_i  (ctrl_q.wave_en),
      .idle_lvl_i (ctrl_q.idle_lvl),
      .hit_i      (hit),
      .wave_o     (wave_out)
   );

   assign tick_irq = hit;

   // R4: single-cycle pulse unless every tick matches
   p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick_irq |=> (!tick_irq || (ctrl_q.csel == '0 && cmp0_q == '0)));

   // R9: spare addresses leave all state untouched
   p_spare_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr[1]) |=> ($stable(ctrl_q) && $stable(cmp0_q)));

   // R10: control byte bit 7 lands in the run bit
   p_ctrl_layout_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADR_CTRL) |=> ctrl_q.run == $past(reg_wdata[7]));

   // R8: non-interval mode never interrupts
   p_mode_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.opmode != OPM_INTERVAL) |-> !tick_irq);

endmodule

// File: tb/cm_interval_timer_tb.sv
module cm_interval_timer_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       tick_irq;
   logic       wave_out;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   cm_interval_timer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .tick_irq  (tick_irq),
      .wave_out  (wave_out)
   );

   task automatic check(input string tag, input logic ei, input logic eo);
      n_chk++;
      if (tick_irq !== ei || wave_out !== eo) begin
         n_bad++;
         $display("FAIL %s: irq=%0b out=%0b expected irq=%0b out=%0b",
                  tag, tick_irq, wave_out, ei, eo);
      end
   endtask

   // called at a negedge; returns at the next negedge
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   function automatic int divisor(input int sel);
      return 1 << ((sel < 3) ? sel : (2 * sel - 2));
   endfunction

   // R10 layout: {run, csel[2:0], mode[1:0], idle, oe}
   task automatic run_check(input string tag, input int n, input int sel,
                            input logic oe, input logic lvl,
                            input int pulses, input logic poke);
      int   per;
      int   total;
      logic par;
      per   = (n + 1) * divisor(sel);
      total = per * pulses + 2;
      par   = 1'b0;
      wr(2'd0, {1'b0, 3'(sel), 2'b00, lvl, oe});
      wr(2'd1, 8'(n));
      wr(2'd0, {1'b1, 3'(sel), 2'b00, lvl, oe});
      for (int c = 0; c < total; c++) begin
         logic ei;
         ei = ((c + 1) % per) == 0;
         if (poke) begin
            reg_we = 1'b1; reg_addr = (c % 2) ? 2'd2 : 2'd3; reg_wdata = 8'(c);
         end
         check(tag, ei, lvl ^ (oe & par));
         if (ei) par = ~par;
         @(negedge clk);
      end
      reg_we = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1 reset values
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 in reset", 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", 1'b0, 1'b0);

      // R3 R2 R4 R5: every clock-select code
      for (int s = 0; s < 8; s++)
         run_check("R3 select sweep", 2, s, 1'b1, 1'b0, 2, 1'b0);

      // R2 R4 R5: compare-value sweep at divisor 1, including N=0 (every tick matches)
      for (int n = 0; n <= 20; n++)
         run_check("R2 compare sweep low", n, 0, 1'b1, (n % 2) != 0, 3, 1'b0);
      for (int n = 240; n <= 255; n++)
         run_check("R2 compare sweep high", n, 0, 1'b1, 1'b0, 3, 1'b0);

      // R4 with divisor 2 and N=0: one-cycle pulses every other cycle
      run_check("R4 narrow period", 0, 1, 1'b1, 1'b1, 6, 1'b0);

      // R6: output enable low, both idle levels
      run_check("R6 idle high", 3, 1, 1'b0, 1'b1, 3, 1'b0);
      run_check("R6 idle low", 5, 0, 1'b0, 1'b0, 3, 1'b0);

      // R9: spare-address writes on every cycle, including match cycles
      run_check("R9 spare writes", 4, 0, 1'b1, 1'b0, 4, 1'b1);
      run_check("R9 spare writes div4", 1, 2, 1'b1, 1'b1, 4, 1'b1);

      // R7: stop just after a toggle, output returns to idle at once
      wr(2'd0, 8'h00);
      wr(2'd1, 8'd3);
      wr(2'd0, {1'b1, 3'd0, 2'b00, 1'b0, 1'b1});
      repeat (5) @(negedge clk);
      check("R7 wave high before stop", 1'b0, 1'b1);
      wr(2'd0, {1'b0, 3'd0, 2'b00, 1'b0, 1'b1});
      for (int c = 0; c < 20; c++) begin
         check("R7 stopped", 1'b0, 1'b0);
         @(negedge clk);
      end
      // R7: a restart follows the R2 timing from a zero count
      run_check("R7 restart", 3, 0, 1'b1, 1'b0, 2, 1'b0);

      // R8: modes 01, 10, 11 never count
      for (int m = 1; m < 4; m++) begin
         wr(2'd0, 8'h00);
         wr(2'd1, 8'd0);
         wr(2'd0, {1'b1, 3'd0, 2'(m), 1'b1, 1'b1});
         for (int c = 0; c < 30; c++) begin
            check("R8 non-interval mode", 1'b0, 1'b1);
            @(negedge clk);
         end
      end
      // R8: back to interval mode, count starts from zero
      run_check("R8 mode restored", 2, 0, 1'b1, 1'b1, 2, 1'b0);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule